// File: doc/BRIEF.md
# Reset Exception Entry Sequencer

This block carries a CPU through reset exception entry. It takes two kinds of request: a power-on reset and a manual reset. After it accepts a request, it waits until no other master holds the bus and no DMA burst is running. It then makes two word reads through a valid/ready read port. The first read returns the initial program counter and the second returns the initial stack pointer. At that point it puts the CPU context back to its entry values, loads the two fetched words, and pulses a start signal for one cycle so that execution can begin.

A manual reset that finds the bus taken waits for it, but only up to a configured number of cycles. If the bus is still taken after that, the request is discarded and a one-cycle dropped pulse is issued. A manual reset restores CPU state only. A power-on reset also pulses a clear-enable output for the floating-point unit and other modules, and no limit applies to its wait.

The context registers (PC, SP, vector base, interrupt mask, the BO and CS status bits, and the register-bank flag for the interrupt controller) live inside the block. Outside an entry sequence the CPU updates them through a write port.

Top module: `rst_entry_seq`

## Requirements
- R1: After reset the block is idle. busy_o, rd_valid, start_o, dropped_o and fpu_clr_o are 0, pc_o, sp_o and vbr_o are 0, imask_o is 4'hF, and bo_o, cs_o and bn_o are 0.
- R2: A power-on entry first reads the PC word at VEC_BASE+0x0 and then the SP word at VEC_BASE+0x4. A manual entry reads at VEC_BASE+0x8 and then VEC_BASE+0xC. rd_valid and rd_addr hold steady until rd_ready is seen.
- R3: pc_o and sp_o keep their old values until both reads have completed. They show the two read words in the one cycle in which start_o is high, and start_o lasts exactly one cycle.
- R4: While start_o is high, vbr_o is 0, imask_o is 4'hF, and bo_o, cs_o and bn_o are 0.
- R5: fpu_clr_o is high for one cycle, together with start_o, on a power-on entry. It is never high on a manual entry.
- R6: No read is started in any cycle in which ext_grant or dma_burst was high at the deciding clock edge.
- R7: A manual request is discarded if the bus stays taken for more than MR_TIMEOUT wait cycles. The first wait cycle is the one after acceptance. On discard, dropped_o pulses for one cycle, busy_o falls, no read is made and the context is unchanged. A wait of exactly MR_TIMEOUT taken cycles still proceeds.
- R8: A power-on entry waits for the bus for any length of time and is never discarded.
- R9: A power-on request wins over a simultaneous manual request. A power-on request that arrives while a manual request is waiting turns it into a power-on entry, even in the cycle the wait limit would expire.
- R10: busy_o is high from the cycle after a request is accepted through the start_o cycle, and falls right after it.
- R11: A manual request made while an entry is running is ignored. A power-on request made during the reads or later is held and runs a second full power-on entry after the first start pulse.
- R12: A CPU write (cpu_we) updates the context registers on the next cycle when idle, and is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| por_req | input | 1 | Power-on reset request, one-cycle pulse |
| mrst_req | input | 1 | Manual reset request, one-cycle pulse |
| ext_grant | input | 1 | Bus is granted to another master |
| dma_burst | input | 1 | A DMA burst transfer is in progress |
| rd_valid | output | 1 | Vector read request valid |
| rd_addr | output | AW | Vector read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | DW | Read data |
| cpu_we | input | 1 | CPU write strobe for the context registers |
| cpu_pc | input | DW | CPU write value for PC |
| cpu_sp | input | DW | CPU write value for SP |
| cpu_vbr | input | DW | CPU write value for vector base |
| cpu_imask | input | IMW | CPU write value for interrupt mask |
| cpu_bo | input | 1 | CPU write value for BO bit |
| cpu_cs | input | 1 | CPU write value for CS bit |
| cpu_bn | input | 1 | CPU write value for register-bank flag |
| pc_o | output | DW | Program counter |
| sp_o | output | DW | Stack pointer |
| vbr_o | output | DW | Vector base register |
| imask_o | output | IMW | Interrupt mask field |
| bo_o | output | 1 | BO status bit |
| cs_o | output | 1 | CS status bit |
| bn_o | output | 1 | Register-bank flag to the interrupt controller |
| fpu_clr_o | output | 1 | Clear enable for FPU and other modules (power-on only) |
| busy_o | output | 1 | Entry sequence in progress |
| start_o | output | 1 | One-cycle start-execution pulse |
| dropped_o | output | 1 | One-cycle pulse: manual request discarded |

## Verification
Two collisions matter most. The first is expiry of the manual wait limit against the bus being freed, or against a power-on request arriving, in the same cycle. The bench sweeps the length of the taken-bus window across the limit: when the bus frees in exactly the cycle in which the counter reaches MR_TIMEOUT, the entry must proceed, and one cycle later it must be dropped. A further case injects a power-on request into the expiry cycle; it must produce power-on reads and no dropped pulse. The second collision is a request that arrives while an entry is running. A late manual request must leave a single start pulse. A late power-on request must produce a second run at the power-on addresses.

// File: rtl/rst_entry_pkg.sv
package rst_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_FETCH_PC,
        ST_FETCH_SP,
        ST_INIT,
        ST_START
    } seq_state_e;

    typedef enum logic {
        KIND_POWER,
        KIND_MANUAL
    } rst_kind_e;

endpackage

// File: rtl/rst_entry_waitcnt.sv
// Counts cycles spent waiting for the bus while it is taken.
// The count is cleared whenever the sequencer is outside the wait state.
module rst_entry_waitcnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    input  logic bus_free,
    output logic expired
);

    generate
        if (LIMIT == 0) begin : g_immediate
            assign expired = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!in_wait) begin
                    cnt_d = '0;
                end else if (!bus_free && (cnt_q != LIM_V)) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expired = (cnt_q == LIM_V);
        end
    endgenerate

endmodule

// File: rtl/rst_entry_ctx.sv
// CPU context registers touched by reset entry.
module rst_entry_ctx #(
    parameter int DW  = 32,
    parameter int IMW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [DW-1:0]  load_pc,
    input  logic [DW-1:0]  load_sp,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_pc,
    input  logic [DW-1:0]  wr_sp,
    input  logic [DW-1:0]  wr_vbr,
    input  logic [IMW-1:0] wr_imask,
    input  logic           wr_bo,
    input  logic           wr_cs,
    input  logic           wr_bn,
    output logic [DW-1:0]  pc,
    output logic [DW-1:0]  sp,
    output logic [DW-1:0]  vbr,
    output logic [IMW-1:0] imask,
    output logic           bo,
    output logic           cs,
    output logic           bn
);

    typedef struct packed {
        logic [DW-1:0]  pc;
        logic [DW-1:0]  sp;
        logic [DW-1:0]  vbr;
        logic [IMW-1:0] imask;
        logic           bo;
        logic           cs;
        logic           bn;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (load) begin
            ctx_d.pc    = load_pc;
            ctx_d.sp    = load_sp;
            ctx_d.vbr   = '0;
            ctx_d.imask = '1;
            ctx_d.bo    = 1'b0;
            ctx_d.cs    = 1'b0;
            ctx_d.bn    = 1'b0;
        end else if (wr_en) begin
            ctx_d.pc    = wr_pc;
            ctx_d.sp    = wr_sp;
            ctx_d.vbr   = wr_vbr;
            ctx_d.imask = wr_imask;
            ctx_d.bo    = wr_bo;
            ctx_d.cs    = wr_cs;
            ctx_d.bn    = wr_bn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q.pc    <= '0;
            ctx_q.sp    <= '0;
            ctx_q.vbr   <= '0;
            ctx_q.imask <= '1;
            ctx_q.bo    <= 1'b0;
            ctx_q.cs    <= 1'b0;
            ctx_q.bn    <= 1'b0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pc    = ctx_q.pc;
    assign sp    = ctx_q.sp;
    assign vbr   = ctx_q.vbr;
    assign imask = ctx_q.imask;
    assign bo    = ctx_q.bo;
    assign cs    = ctx_q.cs;
    assign bn    = ctx_q.bn;

endmodule

// File: rtl/rst_entry_fsm.sv
// Sequencer: request arbitration, bus wait, vector reads, context load, start.
module rst_entry_fsm
    import rst_entry_pkg::*;
#(
    parameter int              AW         = 32,
    parameter int              DW         = 32,
    parameter logic [AW-1:0]   VEC_BASE   = '0,
    parameter int unsigned     OFF_POR_PC = 32'h0,
    parameter int unsigned     OFF_POR_SP = 32'h4,
    parameter int unsigned     OFF_MAN_PC = 32'h8,
    parameter int unsigned     OFF_MAN_SP = 32'hC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_req,
    input  logic          mrst_req,
    input  logic          bus_free,
    input  logic          wait_expired,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          in_wait,
    output logic          ctx_load,
    output logic [DW-1:0] ld_pc,
    output logic [DW-1:0] ld_sp,
    output logic          busy,
    output logic          start,
    output logic          dropped,
    output logic          fpu_clr
);

    localparam logic [AW-1:0] A_POR_PC = VEC_BASE + AW'(OFF_POR_PC);
    localparam logic [AW-1:0] A_POR_SP = VEC_BASE + AW'(OFF_POR_SP);
    localparam logic [AW-1:0] A_MAN_PC = VEC_BASE + AW'(OFF_MAN_PC);
    localparam logic [AW-1:0] A_MAN_SP = VEC_BASE + AW'(OFF_MAN_SP);

    typedef struct packed {
        seq_state_e    st;
        rst_kind_e     kind;
        logic          por_pend;
        logic [DW-1:0] pc_tmp;
        logic [DW-1:0] sp_tmp;
        logic          drop;
        logic          fpu;
    } fsm_t;

    fsm_t r_d, r_q;
    logic load_c;

    always_comb begin
        r_d      = r_q;
        r_d.drop = 1'b0;
        r_d.fpu  = 1'b0;
        load_c   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (por_req) begin
                    r_d.st   = ST_WAIT_BUS;
                    r_d.kind = KIND_POWER;
                end else if (mrst_req) begin
                    r_d.st   = ST_WAIT_BUS;
                    r_d.kind = KIND_MANUAL;
                end
            end
            ST_WAIT_BUS: begin
                if (por_req) r_d.kind = KIND_POWER;
                if (bus_free) begin
                    r_d.st = ST_FETCH_PC;
                end else if (r_q.kind == KIND_MANUAL && !por_req && wait_expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.drop = 1'b1;
                end
            end
            ST_FETCH_PC: begin
                if (por_req) r_d.por_pend = 1'b1;
                if (rd_ready) begin
                    r_d.pc_tmp = rd_data;
                    r_d.st     = ST_FETCH_SP;
                end
            end
            ST_FETCH_SP: begin
                if (por_req) r_d.por_pend = 1'b1;
                if (rd_ready) begin
                    r_d.sp_tmp = rd_data;
                    r_d.st     = ST_INIT;
                end
            end
            ST_INIT: begin
                if (por_req) r_d.por_pend = 1'b1;
                load_c  = 1'b1;
                r_d.fpu = (r_q.kind == KIND_POWER);
                r_d.st  = ST_START;
            end
            ST_START: begin
                if (r_q.por_pend || por_req) begin
                    r_d.st       = ST_WAIT_BUS;
                    r_d.kind     = KIND_POWER;
                    r_d.por_pend = 1'b0;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.kind     <= KIND_POWER;
            r_q.por_pend <= 1'b0;
            r_q.pc_tmp   <= '0;
            r_q.sp_tmp   <= '0;
            r_q.drop     <= 1'b0;
            r_q.fpu      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_addr = '0;
        if (r_q.st == ST_FETCH_PC) begin
            rd_addr = (r_q.kind == KIND_POWER) ? A_POR_PC : A_MAN_PC;
        end else if (r_q.st == ST_FETCH_SP) begin
            rd_addr = (r_q.kind == KIND_POWER) ? A_POR_SP : A_MAN_SP;
        end
    end

    assign rd_valid = (r_q.st == ST_FETCH_PC) || (r_q.st == ST_FETCH_SP);
    assign in_wait  = (r_q.st == ST_WAIT_BUS);
    assign ctx_load = load_c;
    assign ld_pc    = r_q.pc_tmp;
    assign ld_sp    = r_q.sp_tmp;
    assign busy     = (r_q.st != ST_IDLE);
    assign start    = (r_q.st == ST_START);
    assign dropped  = r_q.drop;
    assign fpu_clr  = r_q.fpu;

endmodule

// File: rtl/rst_entry_seq.sv
module rst_entry_seq #(
    parameter int            AW          = 32,
    parameter int            DW          = 32,
    parameter int            IMW         = 4,
    parameter int            MR_TIMEOUT  = 16,
    parameter logic [AW-1:0] VEC_BASE    = '0,
    parameter int unsigned   OFF_POR_PC  = 32'h0,
    parameter int unsigned   OFF_POR_SP  = 32'h4,
    parameter int unsigned   OFF_MAN_PC  = 32'h8,
    parameter int unsigned   OFF_MAN_SP  = 32'hC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           por_req,
    input  logic           mrst_req,
    input  logic           ext_grant,
    input  logic           dma_burst,
    output logic           rd_valid,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_ready,
    input  logic [DW-1:0]  rd_data,
    input  logic           cpu_we,
    input  logic [DW-1:0]  cpu_pc,
    input  logic [DW-1:0]  cpu_sp,
    input  logic [DW-1:0]  cpu_vbr,
    input  logic [IMW-1:0] cpu_imask,
    input  logic           cpu_bo,
    input  logic           cpu_cs,
    input  logic           cpu_bn,
    output logic [DW-1:0]  pc_o,
    output logic [DW-1:0]  sp_o,
    output logic [DW-1:0]  vbr_o,
    output logic [IMW-1:0] imask_o,
    output logic           bo_o,
    output logic           cs_o,
    output logic           bn_o,
    output logic           fpu_clr_o,
    output logic           busy_o,
    output logic           start_o,
    output logic           dropped_o
);

    logic          bus_free;
    logic          in_wait;
    logic          expired;
    logic          ctx_load;
    logic [DW-1:0] ld_pc;
    logic [DW-1:0] ld_sp;
    logic          busy;

    assign bus_free = !ext_grant && !dma_burst;

    rst_entry_waitcnt #(
        .LIMIT (MR_TIMEOUT)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_wait  (in_wait),
        .bus_free (bus_free),
        .expired  (expired)
    );

    rst_entry_fsm #(
        .AW         (AW),
        .DW         (DW),
        .VEC_BASE   (VEC_BASE),
        .OFF_POR_PC (OFF_POR_PC),
        .OFF_POR_SP (OFF_POR_SP),
        .OFF_MAN_PC (OFF_MAN_PC),
        .OFF_MAN_SP (OFF_MAN_SP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_req      (por_req),
        .mrst_req     (mrst_req),
        .bus_free     (bus_free),
        .wait_expired (expired),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_addr      (rd_addr),
        .in_wait      (in_wait),
        .ctx_load     (ctx_load),
        .ld_pc        (ld_pc),
        .ld_sp        (ld_sp),
        .busy         (busy),
        .start        (start_o),
        .dropped      (dropped_o),
        .fpu_clr      (fpu_clr_o)
    );

    rst_entry_ctx #(
        .DW  (DW),
        .IMW (IMW)
    ) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctx_load),
        .load_pc  (ld_pc),
        .load_sp  (ld_sp),
        .wr_en    (cpu_we && !busy),
        .wr_pc    (cpu_pc),
        .wr_sp    (cpu_sp),
        .wr_vbr   (cpu_vbr),
        .wr_imask (cpu_imask),
        .wr_bo    (cpu_bo),
        .wr_cs    (cpu_cs),
        .wr_bn    (cpu_bn),
        .pc       (pc_o),
        .sp       (sp_o),
        .vbr      (vbr_o),
        .imask    (imask_o),
        .bo       (bo_o),
        .cs       (cs_o),
        .bn       (bn_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/rst_entry_chk.sv
module rst_entry_chk #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int IMW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_valid,
    input logic           rd_ready,
    input logic [AW-1:0]  rd_addr,
    input logic           ext_grant,
    input logic           dma_burst,
    input logic [DW-1:0]  vbr_o,
    input logic [IMW-1:0] imask_o,
    input logic           bo_o,
    input logic           cs_o,
    input logic           bn_o,
    input logic           fpu_clr_o,
    input logic           busy_o,
    input logic           start_o,
    input logic           dropped_o
);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R3

    AST_START_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (vbr_o == '0 && imask_o == '1 && !bo_o && !cs_o && !bn_o)); // R4

    AST_FPU_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        fpu_clr_o |-> start_o); // R5

    AST_READ_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!ext_grant && !dma_burst)); // R6

    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dropped_o |-> (!busy_o && !start_o && !rd_valid)); // R7

    AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dropped_o |=> !dropped_o); // R7

    AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o); // R10

endmodule

bind rst_entry_seq rst_entry_chk #(
    .AW  (AW),
    .DW  (DW),
    .IMW (IMW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .ext_grant (ext_grant),
    .dma_burst (dma_burst),
    .vbr_o     (vbr_o),
    .imask_o   (imask_o),
    .bo_o      (bo_o),
    .cs_o      (cs_o),
    .bn_o      (bn_o),
    .fpu_clr_o (fpu_clr_o),
    .busy_o    (busy_o),
    .start_o   (start_o),
    .dropped_o (dropped_o)
);

// File: tb/rst_entry_seq_tb.sv
module rst_entry_seq_tb;

    localparam int TMO = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_req = 1'b0, mrst_req = 1'b0;
    logic        ext_grant = 1'b0, dma_burst = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data = '0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_pc = '0, cpu_sp = '0, cpu_vbr = '0;
    logic [3:0]  cpu_imask = '0;
    logic        cpu_bo = 1'b0, cpu_cs = 1'b0, cpu_bn = 1'b0;
    logic [31:0] pc_o, sp_o, vbr_o;
    logic [3:0]  imask_o;
    logic        bo_o, cs_o, bn_o, fpu_clr_o, busy_o, start_o, dropped_o;

    always #5 clk = ~clk;

    rst_entry_seq #(.MR_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .mrst_req(mrst_req),
        .ext_grant(ext_grant), .dma_burst(dma_burst),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .cpu_we(cpu_we), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp), .cpu_vbr(cpu_vbr),
        .cpu_imask(cpu_imask), .cpu_bo(cpu_bo), .cpu_cs(cpu_cs), .cpu_bn(cpu_bn),
        .pc_o(pc_o), .sp_o(sp_o), .vbr_o(vbr_o), .imask_o(imask_o),
        .bo_o(bo_o), .cs_o(cs_o), .bn_o(bn_o), .fpu_clr_o(fpu_clr_o),
        .busy_o(busy_o), .start_o(start_o), .dropped_o(dropped_o)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // results of one entry run
    int          n_starts, n_drop, n_fpu, n_hs;
    int          fpu_bad, start_wide, rd_busy, busy_hole;
    logic [31:0] hs_addr [0:7];
    logic [31:0] pc_at_start, sp_at_start;
    bit          pc_pre_ok, init_ok;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return 32'h1357_00F0 ^ (a * 32'h0001_0003);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [31:0] seed);
        @(negedge clk);
        cpu_we    = 1'b1;
        cpu_pc    = 32'h4000_0000 | seed;
        cpu_sp    = 32'h7000_0000 | seed;
        cpu_vbr   = 32'h0000_1000 | seed;
        cpu_imask = 4'h2;
        cpu_bo    = 1'b1;
        cpu_cs    = 1'b1;
        cpu_bn    = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        chk(pc_o == (32'h4000_0000 | seed) && vbr_o == (32'h0000_1000 | seed)
            && imask_o == 4'h2 && bo_o && cs_o && bn_o,
            "R12", "idle write", vbr_o, 32'h0000_1000 | seed);
    endtask

    task automatic run_entry(input bit do_por, input bit do_man, input int bus_n,
                             input int lat, input int por_at, input int man_at,
                             input int cpu_at);
        logic [31:0] pc_before, last_pc;
        bit          prev_drv, prev_start, use_dma;
        int          wc;
        n_starts = 0; n_drop = 0; n_fpu = 0; n_hs = 0;
        fpu_bad = 0; start_wide = 0; rd_busy = 0; busy_hole = 0;
        pc_pre_ok = 1'b0; init_ok = 1'b0;
        pc_at_start = '0; sp_at_start = '0;
        use_dma = bus_n[0];
        wc = 0;
        @(negedge clk);
        pc_before  = pc_o;
        last_pc    = pc_o;
        por_req    = do_por;
        mrst_req   = do_man;
        ext_grant  = (bus_n > 0) && !use_dma;
        dma_burst  = (bus_n > 0) && use_dma;
        prev_drv   = (bus_n > 0);
        prev_start = 1'b0;
        for (int cyc = 1; cyc < 400; cyc++) begin
            @(negedge clk);
            por_req  = (cyc == por_at);
            mrst_req = (cyc == man_at);
            cpu_we   = (cyc == cpu_at);
            if (cpu_we) begin
                cpu_vbr = 32'hBAD0_0000;
                cpu_pc  = 32'hBAD0_0004;
            end
            // sample
            if (rd_valid && prev_drv) rd_busy++;
            if (start_o) begin
                n_starts++;
                if (n_starts == 1) pc_pre_ok = (last_pc == pc_before);
                pc_at_start = pc_o;
                sp_at_start = sp_o;
                init_ok = (vbr_o == 32'h0) && (imask_o == 4'hF) && !bo_o && !cs_o && !bn_o;
                if (fpu_clr_o) n_fpu++;
            end
            if (fpu_clr_o && !start_o) fpu_bad++;
            if (prev_start && start_o) start_wide++;
            if (dropped_o) n_drop++;
            if (!busy_o) begin
                if (n_starts == 0 && n_drop == 0) busy_hole++;
                break;
            end
            last_pc = pc_o;
            // drive
            ext_grant = (cyc <= bus_n) && !use_dma;
            dma_burst = (cyc <= bus_n) && use_dma;
            prev_drv  = (cyc <= bus_n);
            if (rd_ready) begin
                rd_ready = 1'b0;
                wc = 0;
            end else if (rd_valid) begin
                if (wc == lat) begin
                    rd_ready = 1'b1;
                    rd_data  = mem_word(rd_addr);
                    if (n_hs < 8) hs_addr[n_hs] = rd_addr;
                    n_hs++;
                end else begin
                    wc++;
                end
            end
            prev_start = start_o;
        end
        por_req = 1'b0; mrst_req = 1'b0; cpu_we = 1'b0;
        ext_grant = 1'b0; dma_burst = 1'b0; rd_ready = 1'b0;
    endtask

    task automatic check_ok_entry(input bit por, input string tag);
        logic [31:0] apc, asp;
        apc = por ? 32'h0 : 32'h8;
        asp = por ? 32'h4 : 32'hC;
        chk(n_starts == 1, "R3", {tag, " start count"}, n_starts, 1);
        chk(n_hs == 2 && hs_addr[0] == apc && hs_addr[1] == asp, "R2",
            {tag, " vector addresses"}, hs_addr[0], apc);
        chk(pc_at_start == mem_word(apc) && sp_at_start == mem_word(asp), "R3",
            {tag, " pc at start"}, pc_at_start, mem_word(apc));
        chk(pc_pre_ok, "R3", {tag, " pc held until start"}, pc_pre_ok, 1);
        chk(init_ok, "R4", {tag, " entry fields"}, vbr_o, 0);
        chk(n_fpu == int'(por) && fpu_bad == 0, "R5", {tag, " fpu clear"}, n_fpu, por);
        chk(start_wide == 0, "R3", {tag, " start width"}, start_wide, 0);
        chk(rd_busy == 0, "R6", {tag, " read while bus taken"}, rd_busy, 0);
        chk(busy_hole == 0, "R10", {tag, " busy window"}, busy_hole, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk(!busy_o && !rd_valid && !start_o && !dropped_o && !fpu_clr_o, "R1",
            "outputs in reset", {busy_o, rd_valid, start_o, dropped_o, fpu_clr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_o == 0 && sp_o == 0 && vbr_o == 0 && imask_o == 4'hF && !bo_o && !cs_o && !bn_o,
            "R1", "context after reset", imask_o, 4'hF);
        chk(!busy_o && !rd_valid, "R1", "idle after reset", busy_o, 0);

        // Sweep: kind x read latency x taken-bus length across the limit
        for (int por = 0; por < 2; por++) begin
            for (int li = 0; li < 3; li++) begin
                for (int n = 0; n <= TMO + 2; n++) begin
                    logic [31:0] seed, vbr_pre, pc_pre;
                    bit exp_drop;
                    seed = 32'((por * 64) + (li * 16) + n + 1);
                    cpu_write(seed);
                    vbr_pre = vbr_o;
                    pc_pre  = pc_o;
                    exp_drop = (por == 0) && (n > TMO);
                    run_entry(por[0], !por[0], n, (li == 2) ? 3 : li, -1, -1,
                              (por == 0) ? 2 : -1);
                    if (exp_drop) begin
                        chk(n_drop == 1 && n_starts == 0, "R7", "manual timeout drop",
                            n_drop, 1);
                        chk(n_hs == 0 && pc_o == pc_pre, "R7", "no read on drop", n_hs, 0);
                        chk(vbr_o == vbr_pre, "R12", "write ignored while busy",
                            vbr_o, vbr_pre);
                    end else begin
                        chk(n_drop == 0, por ? "R8" : "R7", "no drop", n_drop, 0);
                        check_ok_entry(por[0], por ? "por sweep" : "man sweep");
                    end
                end
            end
        end

        // R9: simultaneous requests, power-on wins
        cpu_write(32'h51);
        run_entry(1'b1, 1'b1, 2, 1, -1, -1, -1);
        check_ok_entry(1'b1, "R9 simultaneous");

        // R9: power-on arrives in the expiry cycle of a waiting manual request
        cpu_write(32'h52);
        run_entry(1'b0, 1'b1, TMO + 3, 0, TMO + 1, -1, -1);
        chk(n_drop == 0, "R9", "upgrade at expiry not dropped", n_drop, 0);
        check_ok_entry(1'b1, "R9 upgrade");

        // R8: long wait for power-on
        cpu_write(32'h53);
        run_entry(1'b1, 1'b0, TMO * 10, 2, -1, -1, -1);
        chk(n_drop == 0, "R8", "long power-on wait", n_drop, 0);
        check_ok_entry(1'b1, "R8 long");

        // R11: manual request during a power-on fetch is ignored
        cpu_write(32'h54);
        run_entry(1'b1, 1'b0, 0, 3, -1, 4, -1);
        check_ok_entry(1'b1, "R11 late manual");

        // R11: power-on during a manual fetch runs a second power-on entry
        cpu_write(32'h55);
        run_entry(1'b0, 1'b1, 0, 2, 4, -1, -1);
        chk(n_starts == 2, "R11", "second entry count", n_starts, 2);
        chk(n_hs == 4 && hs_addr[0] == 32'h8 && hs_addr[1] == 32'hC
            && hs_addr[2] == 32'h0 && hs_addr[3] == 32'h4, "R11", "second entry order",
            hs_addr[2], 32'h0);
        chk(pc_at_start == mem_word(32'h0) && sp_at_start == mem_word(32'h4), "R11",
            "second entry pc", pc_at_start, mem_word(32'h0));
        chk(n_fpu == 1 && fpu_bad == 0, "R5", "fpu only on power-on run", n_fpu, 1);
        chk(busy_hole == 0 && start_wide == 0, "R10", "busy across both runs", busy_hole, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule